// File: doc/BRIEF.md
# Scanned Key Matrix Emulator

This block makes a passive key matrix appear to have real keys pressed on it. A controller loads already-translated matrix event codes through a simple write port into a short circular queue. A slow tick, derived from the system clock by a parameterised divider, takes at most one event off the queue and applies it to an internal pressed-key bitmap. A host that scans the matrix drives column strobes into the block and reads row sense lines back. Those lines show, for each row, whether any pressed key in that row sits on a column that is strobed at the moment.

One row code does not describe matrix keys. Events in that row drive a small set of side-band pins instead. These pins stand in for keys that are wired straight to input pins rather than into the matrix. Codes that name a position outside the matrix or outside the side-band set change nothing.

Top module: `key_matrix_player`

## Requirements
- R1: While `rst` is high, and on the clock after it, `sense_out` and `side_out` are zero and `queue_full` is low. Reset also empties the queue and clears every pressed key, so nothing queued before reset is applied after it.
- R2: An event code is 8 bits wide. Bits 6:4 hold the row, bits 3:0 hold the column, and bit 7 set marks a release (bit 7 clear is a press). A press of row r (0..6) and column c (0..10) marks key (r,c) as pressed.
- R3: `sense_out[r]` is high exactly when some pressed key in row r has its column bit in `strobe_in` high. It follows a change of `strobe_in` or of the key state one clock later.
- R4: A release code with row 0..6 and column 0..10 clears key (r,c). Other keys are left alone.
- R5: A code with row field 7 and column field n in 0..4 drives `side_out[n]`: high on a press, low on a release. The matrix is not touched.
- R6: A code that names column 11..15 in rows 0..6, or column field 5..15 in row 7, has no effect on any output.
- R7: Events are applied in the order they were written, at most one per tick, with one tick every `TICK_DIV` clock cycles.
- R8: The queue holds 16 events. `queue_full` is high while it holds 16. A write made while `queue_full` is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write an event code into the queue |
| wr_code | input | 8 | Event code: bit 7 release, bits 6:4 row, bits 3:0 column |
| queue_full | output | 1 | Queue holds 16 events; writes are dropped |
| strobe_in | input | 11 | Column strobes driven by the scanning host |
| sense_out | output | 7 | Row sense lines read by the scanning host |
| side_out | output | 5 | Levels of the directly wired keys |

## Verification
The bench keeps the matrix sizes and the 16-entry queue at their defaults. It sets `TICK_DIV` to 32, so a tick comes every 32 cycles instead of every 1/32 s. With that setting, the ordered playback, the one-event-per-tick pacing and a full queue can all be reached within a few thousand cycles. Because a burst of writes lands far faster than the ticks drain it, the bench can hold the queue full and drop a write whose effect would be visible. It also fires reset while events are still queued.

// File: rtl/kmp_pkg.sv
package kmp_pkg;
  localparam int CODE_W     = 8;
  localparam int ROW_W      = 3;
  localparam int COL_W      = 4;
  localparam int DIRECT_ROW = 7;

  // bit layout matters: release in 7, row in 6:4, column in 3:0
  typedef struct packed {
    logic             release_n;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } key_event_t;
endpackage

// File: rtl/kmp_tick_gen.sv
module kmp_tick_gen #(
  parameter int TICK_DIV = 7812500
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  generate
    if (TICK_DIV > 1) begin : g_spacing_chk
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R7
    end
  endgenerate
endmodule

// File: rtl/kmp_event_fifo.sv
module kmp_event_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         pop_req,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = AW + 1;
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             wr_ok, pop_ok;

  assign full   = (count == CNT_FULL);
  assign wr_ok  = wr_en && !full;
  assign pop_ok = pop_req && (count != '0);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= pop_ok;
      if (wr_ok)  wr_ptr <= step(wr_ptr);
      if (pop_ok) rd_ptr <= step(rd_ptr);
      case ({wr_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_FULL); // R8
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !pop_req) |=> (count == $past(count))); // R8
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(count) != '0); // R7
endmodule

// File: rtl/kmp_matrix_state.sv
module kmp_matrix_state
  import kmp_pkg::*;
#(
  parameter int NUM_STROBE = 11,
  parameter int NUM_SENSE  = 7,
  parameter int NUM_SIDE   = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  evt_valid,
  input  key_event_t            evt,
  input  logic [NUM_STROBE-1:0] strobe_in,
  output logic [NUM_SENSE-1:0]  sense_out,
  output logic [NUM_SIDE-1:0]   side_out
);
  logic [NUM_STROBE-1:0] row_bits [NUM_SENSE];
  logic                  is_direct, in_matrix, in_side;

  assign is_direct = (int'(evt.row) == DIRECT_ROW);
  assign in_matrix = !is_direct && (int'(evt.row) < NUM_SENSE)
                     && (int'(evt.col) < NUM_STROBE);
  assign in_side   = is_direct && (int'(evt.col) < NUM_SIDE);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_SENSE; r++) row_bits[r] <= '0;
    end else if (evt_valid && in_matrix) begin
      for (int r = 0; r < NUM_SENSE; r++)
        for (int c = 0; c < NUM_STROBE; c++)
          if (int'(evt.row) == r && int'(evt.col) == c)
            row_bits[r][c] <= !evt.release_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      side_out <= '0;
    end else if (evt_valid && in_side) begin
      for (int n = 0; n < NUM_SIDE; n++)
        if (int'(evt.col) == n) side_out[n] <= !evt.release_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sense_out <= '0;
    else
      for (int r = 0; r < NUM_SENSE; r++)
        sense_out[r] <= |(row_bits[r] & strobe_in);
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (sense_out == '0 && side_out == '0)); // R1
  AST_NO_STROBE_NO_SENSE: assert property (@(posedge clk) disable iff (rst)
    (strobe_in == '0) |=> (sense_out == '0)); // R3
  AST_SIDE_PRESS: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && in_side && !evt.release_n) |=> side_out[$past(evt.col)]); // R5
  AST_SIDE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && in_side && evt.release_n) |=> !side_out[$past(evt.col)]); // R5
  AST_BAD_SIDE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && is_direct && !in_side) |=> $stable(side_out)); // R6
  AST_IDLE_SIDE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !evt_valid |=> $stable(side_out)); // R7
endmodule

// File: rtl/key_matrix_player.sv
module key_matrix_player
  import kmp_pkg::*;
#(
  parameter int NUM_STROBE  = 11,
  parameter int NUM_SENSE   = 7,
  parameter int NUM_SIDE    = 5,
  parameter int QUEUE_DEPTH = 16,
  parameter int TICK_DIV    = 7812500
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_valid,
  input  logic [CODE_W-1:0]     wr_code,
  output logic                  queue_full,
  input  logic [NUM_STROBE-1:0] strobe_in,
  output logic [NUM_SENSE-1:0]  sense_out,
  output logic [NUM_SIDE-1:0]   side_out
);
  logic              tick;
  logic              evt_valid;
  logic [CODE_W-1:0] evt_raw;
  key_event_t        evt;

  assign evt = key_event_t'(evt_raw);

  kmp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  kmp_event_fifo #(.DEPTH(QUEUE_DEPTH), .W(CODE_W)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_valid),
    .wr_data  (wr_code),
    .full     (queue_full),
    .pop_req  (tick),
    .out_valid(evt_valid),
    .out_data (evt_raw)
  );

  kmp_matrix_state #(
    .NUM_STROBE(NUM_STROBE),
    .NUM_SENSE (NUM_SENSE),
    .NUM_SIDE  (NUM_SIDE)
  ) u_state (
    .clk      (clk),
    .rst      (rst),
    .evt_valid(evt_valid),
    .evt      (evt),
    .strobe_in(strobe_in),
    .sense_out(sense_out),
    .side_out (side_out)
  );

  AST_EVENT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> $past(tick)); // R7
  AST_FULL_AFTER_RESET: assert property (@(posedge clk)
    rst |=> !queue_full); // R1
endmodule

// File: tb/tb_key_matrix_player.sv
`timescale 1ns/1ps
module tb_key_matrix_player;
  localparam int TICK = 32;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_valid;
  logic [7:0]  wr_code;
  logic        queue_full;
  logic [10:0] strobe_in;
  logic [6:0]  sense_out;
  logic [4:0]  side_out;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  key_matrix_player #(.TICK_DIV(TICK)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_code(wr_code),
    .queue_full(queue_full), .strobe_in(strobe_in),
    .sense_out(sense_out), .side_out(side_out)
  );

  typedef struct packed {
    logic [7:0]  code;
    logic [10:0] strobe;
    logic [6:0]  sense;
    logic [4:0]  side;
  } vec_t;

  // cumulative: each row builds on the key state left by the rows above
  localparam vec_t VEC [12] = '{
    '{8'h00, 11'h001, 7'h01, 5'h00},  // R2 press r0c0
    '{8'h25, 11'h001, 7'h01, 5'h00},  // R3 r2c5 unstrobed
    '{8'h25, 11'h020, 7'h04, 5'h00},  // R3 strobe col5 only
    '{8'h6A, 11'h7FF, 7'h45, 5'h00},  // R2 press r6c10
    '{8'h80, 11'h7FF, 7'h44, 5'h00},  // R4 release r0c0
    '{8'h72, 11'h400, 7'h40, 5'h04},  // R5 side 2 high
    '{8'h74, 11'h000, 7'h00, 5'h14},  // R5 side 4 high
    '{8'hF2, 11'h020, 7'h04, 5'h10},  // R5 side 2 low
    '{8'h1B, 11'h7FF, 7'h44, 5'h10},  // R6 column 11 ignored
    '{8'h77, 11'h7FF, 7'h44, 5'h10},  // R6 side 7 ignored
    '{8'hA5, 11'h7FF, 7'h40, 5'h10},  // R4 release r2c5
    '{8'h3F, 11'h7FF, 7'h40, 5'h10}   // R6 column 15 ignored
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] c);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_code  = c;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit saw_full;
    rst = 1'b1; wr_valid = 1'b0; wr_code = '0; strobe_in = 11'h7FF;
    cycles(4);
    check("R1 reset sense", sense_out, 0);
    check("R1 reset side", side_out, 0);
    check("R1 reset full", queue_full, 0);
    rst = 1'b0;

    // table walk: one event then let at least one tick pass
    foreach (VEC[i]) begin
      push(VEC[i].code);
      strobe_in = VEC[i].strobe;
      cycles(3 * TICK + 4);
      check($sformatf("R2-table[%0d] sense", i), sense_out, VEC[i].sense);
      check($sformatf("R5-table[%0d] side", i), side_out, VEC[i].side);
    end

    // R7 pacing: three back-to-back events, only the third is strobed
    strobe_in = 11'h004;
    @(negedge clk); wr_valid = 1'b1; wr_code = 8'h50;
    @(negedge clk); wr_code = 8'h51;
    @(negedge clk); wr_code = 8'h52;
    @(negedge clk); wr_valid = 1'b0;
    cycles(TICK + 1);
    check("R7 third event not yet applied", sense_out, 0);
    cycles(4 * TICK);
    check("R7 third event applied", sense_out, 7'h20);

    // R3 live strobe follows in one clock
    strobe_in = 11'h000;
    cycles(1);
    check("R3 strobe off", sense_out, 0);
    strobe_in = 11'h001;
    cycles(1);
    check("R3 strobe col0", sense_out, 7'h20);

    // R8 fill with harmless codes, then write a release that must be dropped
    saw_full = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (queue_full) begin
        saw_full = 1'b1;
        wr_valid = 1'b1; wr_code = 8'hD0;
        break;
      end
      wr_valid = 1'b1; wr_code = 8'h3F;
    end
    @(negedge clk); wr_valid = 1'b0;
    check("R8 full flag seen", int'(saw_full), 1);
    cycles(20 * TICK);
    check("R8 write while full dropped", sense_out, 7'h20);
    check("R8 full clears after drain", queue_full, 0);

    // R1 reset while events wait in the queue
    strobe_in = 11'h7FF;
    push(8'h60);
    push(8'h40);
    rst = 1'b1;
    cycles(2);
    check("R1 mid reset sense", sense_out, 0);
    check("R1 mid reset side", side_out, 0);
    rst = 1'b0;
    cycles(4 * TICK);
    check("R1 queue emptied by reset", sense_out, 0);
    check("R1 side stays low", side_out, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule